// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits in front of a DMA transfer engine and decides which of four channels the engine serves next. Each channel can be asked to move data in two ways. Software can raise a one-cycle request strobe. A peripheral can hold any of four level request lines: burst transmit, one-item transmit, burst receive and one-item receive. The block latches each accepted request as a pending flag. Whenever the engine is free, it grants one pending channel. The search for the next channel rotates, so no channel can starve the others.

While a grant is active the block holds the channel number steady and tells the engine whether the request covers one data item or a full burst. The engine ends the grant with a `done` strobe. For a request that came from peripheral lines, the block acknowledges the peripheral on that channel's request-clear output. A per-channel mode bit selects the acknowledge style: a one-cycle pulse, or a level held until the peripheral drops its lines. The status of each channel is reported as idle, pending or busy.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset every channel status is idle (2'b00), `grant_valid` is 0 and every `req_clr` bit is 0.
- R2: On an enabled channel that is neither pending nor being granted in that cycle, a `sw_req` strobe or any high peripheral line sets its status to pending (2'b01) from the next cycle.
- R3: While a channel's enable bit is 0, requests on that channel are ignored. From the cycle after the enable drops, the channel's status shows no pending request, and the channel is never granted while disabled.
- R4: When no grant is active and at least one enabled channel is pending, the next cycle shows `grant_valid`=1, `grant_ch` equal to the selected channel, and that channel's status as busy (2'b10). Its pending flag is cleared. At most one channel is busy at any time.
- R5: The arbiter searches for a pending channel starting at the channel numbered one above the last released grant, wrapping from 3 to 0. The search starts at channel 0 after reset. The start point moves only when a grant is released.
- R6: A grant stays valid, with `grant_ch` unchanged, until `done` is sampled high while `grant_valid`=1. `grant_valid` is 0 in the next cycle. A `done` strobe while no grant is active has no effect.
- R7: `grant_single` is 1 when the granted request was captured only from one-item lines (`per_tx_one` or `per_rx_one`), with no burst line and no `sw_req` in the capture cycle. Otherwise it is 0, and the granted request is a burst.
- R8: With `clr_hold`=0, `req_clr` of a channel is high for exactly one cycle, the first cycle of a grant to a request captured from peripheral lines. It stays low for grants to software-captured requests.
- R9: With `clr_hold`=1, `req_clr` rises in the first cycle of such a grant. It stays high until the cycle after all four peripheral lines of that channel are low.
- R10: After a grant to a peripheral-captured request, that channel's peripheral lines are ignored until all four have been seen low.
- R11: Busy takes precedence over pending in the status encoding. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_enable | input | 4 | Per-channel enable |
| sw_req | input | 4 | Per-channel software request strobe |
| per_tx | input | 4 | Peripheral burst transmit request, level |
| per_tx_one | input | 4 | Peripheral one-item transmit request, level |
| per_rx | input | 4 | Peripheral burst receive request, level |
| per_rx_one | input | 4 | Peripheral one-item receive request, level |
| clr_hold | input | 4 | Request-clear style: 0 pulse, 1 hold until lines drop |
| done | input | 1 | Engine ends the active grant |
| grant_valid | output | 1 | A grant is active |
| grant_ch | output | 2 | Granted channel number |
| grant_single | output | 1 | Active grant covers one data item only |
| req_clr | output | 4 | Per-channel request-clear acknowledge to the peripheral |
| ch_status | output | 8 | Two bits per channel, channel n at [2n+1:2n]: 00 idle, 01 pending, 10 busy |

## Verification
The assertions check the following properties on every cycle:
- The status encoding is legal and at most one channel is busy.
- The granted channel reads busy, and a held grant keeps its channel number.
- A grant ends one cycle after `done`.
- A disabled channel never shows pending.
- A pulse-style clear lasts one cycle.
- A hold-style clear falls once the lines are low.

Some behaviour can only be shown by the bench's scenarios against its reference model. That covers the round-robin order after each release, one-item versus burst classification, the masking of peripheral lines still held after a grant, and the exact cycle each request becomes pending and then busy.

// File: rtl/dma_arb_pkg.sv
// Package: shared status encoding for the DMA channel request arbiter.
// Assumes two status bits per channel; 2'b11 is unused.
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PEND = 2'b01,
        ST_BUSY = 2'b10
    } ch_state_e;
endpackage

// File: rtl/dma_arb_chan.sv
// Module: one channel's request front end.
// Latches software and peripheral requests into a pending flag. Records
// whether the request is one-item or burst, and whether it came from the
// peripheral. After a grant to a peripheral request, the lines are masked
// until they all drop. Drives the request-clear acknowledge.
// Assumes `take` is only raised while the channel is pending and enabled.
module dma_arb_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sw_req,
    input  logic tx,
    input  logic tx_one,
    input  logic rx,
    input  logic rx_one,
    input  logic clr_hold,
    input  logic take,
    output logic pend,
    output logic single,
    output logic req_clr
);
    logic from_hw;
    logic ack_wait;
    logic clr_pulse;
    logic hw_any;
    logic burst_line;
    logic hw_ok;
    logic capture;

    // Classify this cycle's request lines and decide whether to latch them.
    always_comb begin
        hw_any     = tx | tx_one | rx | rx_one;
        burst_line = tx | rx;
        hw_ok      = hw_any & ~ack_wait;
        capture    = en & ~pend & ~take & (sw_req | hw_ok);
    end

    // Pending flag with its one-item and source attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            single  <= 1'b0;
            from_hw <= 1'b0;
        end else if (!en || take) begin
            pend <= 1'b0;
        end else if (capture) begin
            pend    <= 1'b1;
            single  <= hw_ok & ~burst_line & ~sw_req;
            from_hw <= hw_ok;
        end
    end

    // Mask the peripheral lines from a hardware grant until they all drop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_wait <= 1'b0;
        else if (take && from_hw)
            ack_wait <= 1'b1;
        else if (!hw_any)
            ack_wait <= 1'b0;
    end

    // One-cycle acknowledge in the first grant cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clr_pulse <= 1'b0;
        else
            clr_pulse <= take & from_hw;
    end

    // Select the acknowledge style for this channel.
    assign req_clr = clr_hold ? ack_wait : clr_pulse;
endmodule

// File: rtl/dma_arb_rr.sv
// Module: round-robin selector.
// Finds the first eligible channel at or after the rotating start point.
// The start point moves to one past the released channel whenever a grant
// ends. Assumes NCH >= 2.
module dma_arb_rr #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  eligible,
    input  logic            release_en,
    input  logic [CH_W-1:0] last_ch,
    output logic            sel_valid,
    output logic [CH_W-1:0] sel_ch
);
    logic [CH_W-1:0] ptr;

    // Advance the start point past the channel whose grant just ended.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (release_en) begin
            if (last_ch == CH_W'(NCH - 1))
                ptr <= '0;
            else
                ptr <= last_ch + 1'b1;
        end
    end

    // Rotating priority search; the lowest offset from ptr is written last and wins.
    always_comb begin
        sel_valid = 1'b0;
        sel_ch    = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            int idx;
            idx = int'(ptr) + i;
            if (idx >= NCH)
                idx = idx - NCH;
            if (eligible[idx]) begin
                sel_valid = 1'b1;
                sel_ch    = CH_W'(idx);
            end
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
// Module: DMA channel request arbiter (top).
// Gathers per-channel requests, grants one channel at a time to the
// transfer engine in round-robin order, holds the grant until `done`, and
// reports per-channel idle/pending/busy status.
// Assumes `done` is a strobe from the engine and the inputs are synchronous to clk.
module dma_req_arbiter #(
    parameter int NCH = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    ch_enable,
    input  logic [NCH-1:0]    sw_req,
    input  logic [NCH-1:0]    per_tx,
    input  logic [NCH-1:0]    per_tx_one,
    input  logic [NCH-1:0]    per_rx,
    input  logic [NCH-1:0]    per_rx_one,
    input  logic [NCH-1:0]    clr_hold,
    input  logic              done,
    output logic              grant_valid,
    output logic [CH_W-1:0]   grant_ch,
    output logic              grant_single,
    output logic [NCH-1:0]    req_clr,
    output logic [2*NCH-1:0]  ch_status
);
    import dma_arb_pkg::*;

    logic [NCH-1:0] pend_vec;
    logic [NCH-1:0] single_vec;
    logic [NCH-1:0] eligible;
    logic [NCH-1:0] take_vec;
    logic           sel_valid;
    logic [CH_W-1:0] sel_ch;
    logic           fire;
    logic           release_en;

    // Decide when a new grant is issued and when the current one ends.
    always_comb begin
        eligible   = pend_vec & ch_enable;
        fire       = ~grant_valid & sel_valid;
        release_en = grant_valid & done;
    end

    dma_arb_rr #(.NCH(NCH), .CH_W(CH_W)) u_rr (
        .clk        (clk),
        .rst_n      (rst_n),
        .eligible   (eligible),
        .release_en (release_en),
        .last_ch    (grant_ch),
        .sel_valid  (sel_valid),
        .sel_ch     (sel_ch)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign take_vec[g] = fire && (sel_ch == CH_W'(g));

        dma_arb_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_enable[g]),
            .sw_req   (sw_req[g]),
            .tx       (per_tx[g]),
            .tx_one   (per_tx_one[g]),
            .rx       (per_rx[g]),
            .rx_one   (per_rx_one[g]),
            .clr_hold (clr_hold[g]),
            .take     (take_vec[g]),
            .pend     (pend_vec[g]),
            .single   (single_vec[g]),
            .req_clr  (req_clr[g])
        );

        // Status encoding; busy wins over pending.
        assign ch_status[2*g +: 2] = (grant_valid && grant_ch == CH_W'(g)) ? ST_BUSY :
                                     pend_vec[g] ? ST_PEND : ST_IDLE;
    end

    // Grant register: issue on fire, hold until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid  <= 1'b0;
            grant_ch     <= '0;
            grant_single <= 1'b0;
        end else if (release_en) begin
            grant_valid <= 1'b0;
        end else if (fire) begin
            grant_valid  <= 1'b1;
            grant_ch     <= sel_ch;
            grant_single <= single_vec[sel_ch];
        end
    end
endmodule

// File: rtl/dma_arb_checker.sv
// Module: assertion checker for dma_req_arbiter, attached by bind.
// Assumes the status encoding from dma_arb_pkg.
module dma_arb_checker #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    ch_enable,
    input logic [NCH-1:0]    per_tx,
    input logic [NCH-1:0]    per_tx_one,
    input logic [NCH-1:0]    per_rx,
    input logic [NCH-1:0]    per_rx_one,
    input logic [NCH-1:0]    clr_hold,
    input logic              done,
    input logic              grant_valid,
    input logic [CH_W-1:0]   grant_ch,
    input logic [NCH-1:0]    req_clr,
    input logic [2*NCH-1:0]  ch_status
);
    logic [NCH-1:0] busy_bits;

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assign busy_bits[c] = ch_status[2*c+1];

        // R11: encoding 2'b11 never appears
        a_r11_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
            ch_status[2*c +: 2] != 2'b11);

        // R3: a disabled channel shows no pending request one cycle later
        a_r3_disabled_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_enable[c] |=> ch_status[2*c +: 2] != 2'b01);

        // R8: pulse-style clear lasts a single cycle
        a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            req_clr[c] && !clr_hold[c] |=> !req_clr[c] || clr_hold[c]);

        // R9: hold-style clear falls once all request lines are low
        a_r9_hold_drops: assert property (@(posedge clk) disable iff (!rst_n)
            req_clr[c] && clr_hold[c] &&
            !(per_tx[c] | per_tx_one[c] | per_rx[c] | per_rx_one[c]) |=> !req_clr[c]);
    end

    // R4: at most one busy channel
    a_r4_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_bits));

    // R4: the granted channel reports busy
    a_r4_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> busy_bits[grant_ch]);

    // R6: a grant without done is held with the same channel
    a_r6_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !done |=> grant_valid && $stable(grant_ch));

    // R6: done releases the grant in the next cycle
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && done |=> !grant_valid);
endmodule

bind dma_req_arbiter dma_arb_checker #(.NCH(NCH), .CH_W(CH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_enable    (ch_enable),
    .per_tx       (per_tx),
    .per_tx_one   (per_tx_one),
    .per_rx       (per_rx),
    .per_rx_one   (per_rx_one),
    .clr_hold     (clr_hold),
    .done         (done),
    .grant_valid  (grant_valid),
    .grant_ch     (grant_ch),
    .req_clr      (req_clr),
    .ch_status    (ch_status)
);

// File: tb/tb_dma_req_arbiter.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the arbiter, compared every clock,
// plus directed scenarios for each requirement.
module tb_dma_req_arbiter;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] ch_enable = '0, sw_req = '0, per_tx = '0, per_tx_one = '0;
    logic [N-1:0] per_rx = '0, per_rx_one = '0, clr_hold = '0;
    logic done = 1'b0;
    logic grant_valid, grant_single;
    logic [1:0] grant_ch;
    logic [N-1:0] req_clr;
    logic [2*N-1:0] ch_status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dma_req_arbiter #(.NCH(N)) dut (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .sw_req(sw_req),
        .per_tx(per_tx), .per_tx_one(per_tx_one), .per_rx(per_rx),
        .per_rx_one(per_rx_one), .clr_hold(clr_hold), .done(done),
        .grant_valid(grant_valid), .grant_ch(grant_ch), .grant_single(grant_single),
        .req_clr(req_clr), .ch_status(ch_status)
    );

    // Reference model state
    int m_pend[N], m_sing[N], m_hw[N], m_mask[N], m_pul[N];
    int m_busy, m_gch, m_gsing, m_ptr;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each rising edge using the inputs applied before it.
    always @(posedge clk) begin
        int sel;
        if (!rst_n) begin
            for (int c = 0; c < N; c++) begin
                m_pend[c] = 0; m_sing[c] = 0; m_hw[c] = 0; m_mask[c] = 0; m_pul[c] = 0;
            end
            m_busy = 0; m_gch = 0; m_gsing = 0; m_ptr = 0;
        end else begin
            sel = -1;
            if (!m_busy)
                for (int i = 0; i < N; i++) begin
                    int c;
                    c = (m_ptr + i) % N;
                    if (sel < 0 && m_pend[c] != 0 && ch_enable[c]) sel = c;
                end
            for (int c = 0; c < N; c++) begin
                bit any, burst, hwok, tk;
                any   = per_tx[c] | per_tx_one[c] | per_rx[c] | per_rx_one[c];
                burst = per_tx[c] | per_rx[c];
                hwok  = any && m_mask[c] == 0;
                tk    = (sel == c);
                m_pul[c] = (tk && m_hw[c] != 0) ? 1 : 0;
                if (tk && m_hw[c] != 0) m_mask[c] = 1;
                else if (!any) m_mask[c] = 0;
                if (!ch_enable[c] || tk) m_pend[c] = 0;
                else if (m_pend[c] == 0 && (sw_req[c] || hwok)) begin
                    m_pend[c] = 1;
                    m_sing[c] = (hwok && !burst && !sw_req[c]) ? 1 : 0;
                    m_hw[c]   = hwok ? 1 : 0;
                end
            end
            if (m_busy != 0 && done) begin
                m_busy = 0;
                m_ptr  = (m_gch + 1) % N;
            end else if (sel >= 0) begin
                m_busy  = 1;
                m_gch   = sel;
                m_gsing = m_sing[sel];
            end
        end
    end

    // Compare the outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 grant_valid", int'(grant_valid), m_busy);
            if (m_busy != 0) begin
                chk("R5 grant_ch", int'(grant_ch), m_gch);
                chk("R7 grant_single", int'(grant_single), m_gsing);
            end
            for (int c = 0; c < N; c++) begin
                int st;
                st = (m_busy != 0 && m_gch == c) ? 2 : (m_pend[c] != 0 ? 1 : 0);
                chk("R11 status", int'(ch_status[2*c +: 2]), st);
                chk(clr_hold[c] ? "R9 req_clr" : "R8 req_clr", int'(req_clr[c]),
                    clr_hold[c] ? m_mask[c] : m_pul[c]);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic strobe_done();
        done = 1'b1; tick(); done = 1'b0;
    endtask

    function automatic int st(int c);
        return int'(ch_status[2*c +: 2]);
    endfunction

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk("R1 grant_valid", int'(grant_valid), 0);
        chk("R1 status", int'(ch_status), 0);
        chk("R1 req_clr", int'(req_clr), 0);
        ch_enable = 4'hF;

        // R2: software request becomes pending, then R4 grant
        sw_req[0] = 1'b1; tick(); sw_req[0] = 1'b0;
        chk("R2 pending ch0", st(0), 1);
        tick();
        chk("R4 busy ch0", st(0), 2);
        chk("R8 no clear for sw", int'(req_clr[0]), 0);

        // R3: ch3 pending while busy, then disabled
        sw_req[3] = 1'b1; tick(); sw_req[3] = 1'b0;
        chk("R3 pending ch3", st(3), 1);
        ch_enable[3] = 1'b0; tick();
        chk("R3 cleared ch3", st(3), 0);
        strobe_done();
        chk("R6 released", int'(grant_valid), 0);
        tick(2);
        chk("R3 not granted", int'(grant_valid), 0);
        ch_enable[3] = 1'b1;

        // R6: done while idle has no effect
        strobe_done(); tick();
        chk("R6 idle done", int'(grant_valid), 0);

        // R5: all four at once; start point is ch1 after ch0 release
        sw_req = 4'hF; tick(); sw_req = '0; tick();
        chk("R5 first ch1", int'(grant_ch), 1);
        for (int k = 0; k < 4; k++) begin
            strobe_done(); tick();
        end
        chk("R5 all served", int'(ch_status), 0);

        // R7/R8: one-item transmit on ch2, pulse clear
        per_tx_one[2] = 1'b1; tick(2);
        chk("R7 single", int'(grant_single), 1);
        chk("R8 pulse high", int'(req_clr[2]), 1);
        tick();
        chk("R8 pulse low", int'(req_clr[2]), 0);
        per_tx_one[2] = 1'b0; strobe_done(); tick();

        // R9/R10: burst receive on ch1 with held clear
        clr_hold[1] = 1'b1; per_rx[1] = 1'b1; tick(2);
        chk("R7 burst", int'(grant_single), 0);
        tick(3);
        chk("R9 held", int'(req_clr[1]), 1);
        strobe_done(); tick(3);
        chk("R10 masked", st(1), 0);
        per_rx[1] = 1'b0; tick();
        chk("R9 dropped", int'(req_clr[1]), 0);
        clr_hold[1] = 1'b0;
        tick(2);

        // Mixed stimulus compared against the model every cycle
        for (int k = 0; k < 4000; k++) begin
            for (int c = 0; c < N; c++) begin
                sw_req[c] = ($urandom_range(7) == 0);
                if ($urandom_range(5) == 0) per_tx[c] = ~per_tx[c];
                if ($urandom_range(7) == 0) per_tx_one[c] = ~per_tx_one[c];
                if ($urandom_range(7) == 0) per_rx[c] = ~per_rx[c];
                if ($urandom_range(5) == 0) per_rx_one[c] = ~per_rx_one[c];
                if ($urandom_range(40) == 0) clr_hold[c] = ~clr_hold[c];
                if ($urandom_range(30) == 0) ch_enable[c] = ~ch_enable[c];
            end
            done = ($urandom_range(3) == 0);
            tick();
        end
        sw_req = '0; done = 1'b0;
        tick(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule